// File: doc/BRIEF.md
# Delay-Slot Fetch Sequencer

This block owns the program counter of a 32-bit RISC pipeline front end whose branches may carry one delay slot and whose instruction set has an immediate-prefix instruction. An external decoder presents, for the instruction at the current fetch address, a set of attributes: branch or return, taken, delay slot wanted, target, immediate prefix, breakpoint, halt encoding and unknown opcode. The decoder also passes the register write of that instruction. The attributes are valid in the cycle `ins_done` is high. The sequencer then picks the next fetch address, keeps the prefix-valid flag and raises exceptions.

A taken branch with a delay slot sends the fetch on to the word after the branch. Once that one instruction completes, the fetch goes to the saved target. A branch or return in the slot is illegal. A breakpoint in the slot is dropped without effect. Illegal instructions, breakpoints and the halt encoding stop fetching until reset. The single-step input instead reports a trap after every completed instruction and lets the program go on.

Top module: `dslot_fetch_seq`

## Requirements
- R1: After reset `pc` is 0, `prefix_valid` is 0, `exc_valid` is 0, `fetch_req` is 1 and `fetch_addr` is 0.
- R2: `fetch_addr` equals `pc` with bits 1:0 forced to 0, including after a redirect to an unaligned target.
- R3: An ordinary completed instruction (no branch taken, no exception) advances `pc` by 4 one clock after `ins_done`.
- R4: A taken branch without a delay slot loads `pc` with `br_target` one clock later. A branch that is not taken advances `pc` by 4.
- R5: A taken branch with a delay slot first moves `pc` to the branch address plus 4. When the slot instruction completes, `pc` becomes the saved target.
- R6: A branch or return in a delay slot raises `exc_valid` for one cycle with `exc_code` 2 (illegal). It then stops fetching: `fetch_req` goes to 0 and `pc` holds.
- R7: A breakpoint in a delay slot raises no exception, and `pc` still moves to the saved target.
- R8: A breakpoint outside a delay slot raises `exc_code` 1 (trap), holds `pc` and stops fetching.
- R9: After each completed instruction, the slot instruction included, `prefix_valid` equals that instruction's `is_prefix`.
- R10: The halt encoding raises `exc_code` 3 (exit) and stops fetching.
- R11: An unknown opcode raises `exc_code` 2 (illegal). After any stop, `ins_done` is ignored until reset.
- R12: With `step_en` high, each instruction that completes without another exception gives a one-cycle `exc_code` 1 (trap), and fetching goes on.
- R13: `rf_we` is `wb_we` with writes to register index 0 suppressed, so register 0 stays zero.
- R14: While `ins_done` is low, `pc`, `prefix_valid` and the sequencing state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Single-step trap after each instruction |
| ins_done | input | 1 | Decoded attributes valid; instruction completes this cycle |
| is_branch | input | 1 | Instruction is a branch or return |
| br_taken | input | 1 | Branch is taken |
| br_slot | input | 1 | Taken branch has a delay slot |
| br_target | input | 32 | Branch target address |
| is_prefix | input | 1 | Instruction is the immediate prefix |
| is_brk | input | 1 | Instruction is a breakpoint |
| is_halt | input | 1 | Instruction is the halt encoding |
| is_unknown | input | 1 | Opcode not recognised |
| wb_we | input | 1 | Register write requested |
| wb_idx | input | 5 | Destination register index |
| fetch_req | output | 1 | Fetch active (0 once stopped) |
| fetch_addr | output | 32 | Word-aligned fetch address |
| pc | output | 32 | Program counter |
| prefix_valid | output | 1 | Previous instruction was the immediate prefix |
| rf_we | output | 1 | Register write enable with index 0 masked |
| exc_valid | output | 1 | One-cycle exception indication |
| exc_code | output | 2 | 1 trap, 2 illegal, 3 exit |

## Verification
The bench runs straight-line code, idle gaps, taken and not-taken branches, and slotted branches with an unaligned target. Together these separate the pc+4 path, the direct redirect and the two-step slot redirect. The slot is then filled in turn with the prefix, a breakpoint, a branch and the halt encoding. That shows the slot keeps the prefix rule, drops breakpoints and traps branches. Single-step runs over a slotted branch show that the trap does not stop fetching. Writes to index 0 and to other indices test the register-zero guard.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned ALIGN_BITS = 2;

  typedef enum logic [1:0] {
    SQ_RUN  = 2'd0,
    SQ_SLOT = 2'd1,
    SQ_STOP = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    EX_NONE  = 2'd0,
    EX_TRAP  = 2'd1,
    EX_ILL   = 2'd2,
    EX_EXIT  = 2'd3
  } exc_code_e;
endpackage

// File: rtl/dsf_ctrl.sv
module dsf_ctrl
  import dsf_pkg::*;
#(
  parameter int unsigned ADDR_W = AW
) (
  input  seq_state_e        state_q,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [ADDR_W-1:0] tgt_q,
  input  logic              step_en,
  input  logic              ins_done,
  input  logic              is_branch,
  input  logic              br_taken,
  input  logic              br_slot,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              is_prefix,
  input  logic              is_brk,
  input  logic              is_halt,
  input  logic              is_unknown,
  output logic              upd_en,
  output seq_state_e        state_d,
  output logic [ADDR_W-1:0] pc_d,
  output logic [ADDR_W-1:0] tgt_d,
  output logic              pre_d,
  output logic              exc_d,
  output exc_code_e         code_d
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic active;
  logic in_slot;
  logic fault;
  logic [ADDR_W-1:0] seq_pc;

  assign active  = ins_done && (state_q != SQ_STOP);
  assign in_slot = (state_q == SQ_SLOT);
  assign seq_pc  = pc_q + STEP;
  assign upd_en  = active;
  // Illegal, exit, or breakpoint outside the slot.
  assign fault   = is_unknown || is_halt || (in_slot ? is_branch : is_brk);

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    tgt_d   = tgt_q;
    pre_d   = is_prefix;
    exc_d   = 1'b0;
    code_d  = EX_NONE;
    if (fault) begin
      state_d = SQ_STOP;
      pre_d   = 1'b0;
      exc_d   = 1'b1;
      if (is_unknown || (in_slot && is_branch)) begin
        code_d = EX_ILL;
      end else if (is_halt) begin
        code_d = EX_EXIT;
      end else begin
        code_d = EX_TRAP;
      end
    end else begin
      if (in_slot) begin
        pc_d    = tgt_q;
        state_d = SQ_RUN;
        pre_d   = is_prefix && !is_brk;
      end else if (is_branch && br_taken && br_slot) begin
        pc_d    = seq_pc;
        tgt_d   = br_target;
        state_d = SQ_SLOT;
      end else if (is_branch && br_taken) begin
        pc_d = br_target;
      end else begin
        pc_d = seq_pc;
      end
      if (step_en) begin
        exc_d  = 1'b1;
        code_d = EX_TRAP;
      end
    end
  end
endmodule

// File: rtl/dsf_regs.sv
module dsf_regs
  import dsf_pkg::*;
#(
  parameter int unsigned ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              ins_done,
  input  logic              is_prefix,
  input  seq_state_e        state_d,
  input  logic [ADDR_W-1:0] pc_d,
  input  logic [ADDR_W-1:0] tgt_d,
  input  logic              pre_d,
  input  logic              exc_d,
  input  exc_code_e         code_d,
  output seq_state_e        state_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] tgt_q,
  output logic              pre_q,
  output logic              exc_q,
  output exc_code_e         code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_RUN;
      pc_q    <= '0;
      tgt_q   <= '0;
      pre_q   <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      pc_q    <= pc_d;
      tgt_q   <= tgt_d;
      pre_q   <= pre_d;
    end
  end

  // Exception indication is a one-cycle pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q  <= 1'b0;
      code_q <= EX_NONE;
    end else begin
      exc_q  <= upd_en && exc_d;
      code_q <= (upd_en && exc_d) ? code_d : EX_NONE;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_done |=> ($stable(pc_q) && $stable(state_q) && $stable(pre_q))) else $error("idle update"); // R14
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_STOP) |=> (state_q == SQ_STOP)) else $error("stop left"); // R11
  AST_FATAL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_q && (code_q != EX_TRAP)) |-> (state_q == SQ_STOP)) else $error("fatal without stop"); // R6
  AST_PREFIX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_done && (state_q != SQ_STOP) && !is_prefix) |=> !pre_q) else $error("prefix kept"); // R9
endmodule

// File: rtl/dsf_wb_guard.sv
module dsf_wb_guard
  import dsf_pkg::*;
#(
  parameter int unsigned IDX_W = RIDX_W
) (
  input  logic             wb_we,
  input  logic [IDX_W-1:0] wb_idx,
  output logic             rf_we
);
  localparam logic [IDX_W-1:0] ZERO_REG = '0;
  assign rf_we = wb_we && (wb_idx != ZERO_REG);
endmodule

// File: rtl/dslot_fetch_seq.sv
module dslot_fetch_seq
  import dsf_pkg::*;
#(
  parameter int unsigned ADDR_W = AW,
  parameter int unsigned IDX_W  = RIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              ins_done,
  input  logic              is_branch,
  input  logic              br_taken,
  input  logic              br_slot,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              is_prefix,
  input  logic              is_brk,
  input  logic              is_halt,
  input  logic              is_unknown,
  input  logic              wb_we,
  input  logic [IDX_W-1:0]  wb_idx,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] pc,
  output logic              prefix_valid,
  output logic              rf_we,
  output logic              exc_valid,
  output logic [1:0]        exc_code
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d, tgt_q, tgt_d;
  logic              pre_q, pre_d, exc_q, exc_d, upd_en;
  exc_code_e         code_q, code_d;

  dsf_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .state_q(state_q), .pc_q(pc_q), .tgt_q(tgt_q), .step_en(step_en),
    .ins_done(ins_done), .is_branch(is_branch), .br_taken(br_taken),
    .br_slot(br_slot), .br_target(br_target), .is_prefix(is_prefix),
    .is_brk(is_brk), .is_halt(is_halt), .is_unknown(is_unknown),
    .upd_en(upd_en), .state_d(state_d), .pc_d(pc_d), .tgt_d(tgt_d),
    .pre_d(pre_d), .exc_d(exc_d), .code_d(code_d)
  );

  dsf_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .ins_done(ins_done),
    .is_prefix(is_prefix), .state_d(state_d), .pc_d(pc_d), .tgt_d(tgt_d),
    .pre_d(pre_d), .exc_d(exc_d), .code_d(code_d), .state_q(state_q),
    .pc_q(pc_q), .tgt_q(tgt_q), .pre_q(pre_q), .exc_q(exc_q), .code_q(code_q)
  );

  dsf_wb_guard #(.IDX_W(IDX_W)) guard_i (
    .wb_we(wb_we), .wb_idx(wb_idx), .rf_we(rf_we)
  );

  assign fetch_req    = (state_q != SQ_STOP);
  assign fetch_addr   = {pc_q[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign pc           = pc_q;
  assign prefix_valid = pre_q;
  assign exc_valid    = exc_q;
  assign exc_code     = code_q;

  AST_SLOT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SLOT && ins_done && !is_branch && !is_unknown && !is_halt)
    |=> (pc == $past(tgt_q))) else $error("slot return"); // R5
  AST_SLOT_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SLOT && ins_done && is_branch)
    |=> (exc_valid && exc_code == 2'd2 && !fetch_req)) else $error("slot branch"); // R6
  AST_R0_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && wb_idx != '0) |-> rf_we) else $error("write lost"); // R13
endmodule

// File: tb/dslot_fetch_seq_tb.sv
module dslot_fetch_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, step_en = 1'b0, ins_done = 1'b0;
  logic is_branch = 1'b0, br_taken = 1'b0, br_slot = 1'b0, is_prefix = 1'b0;
  logic is_brk = 1'b0, is_halt = 1'b0, is_unknown = 1'b0, wb_we = 1'b0;
  logic [31:0] br_target = '0;
  logic [4:0] wb_idx = '0;
  logic fetch_req, prefix_valid, rf_we, exc_valid;
  logic [31:0] fetch_addr, pc;
  logic [1:0] exc_code;

  int errors = 0, checks = 0;
  bit done = 0;
  string req = "R1";
  // reference model: 0 run, 1 slot, 2 stopped
  int m_st = 0;
  logic [31:0] m_pc = 0, m_tgt = 0;
  bit m_pre = 0, m_ev = 0;
  int m_ec = 0;

  always #5 clk = ~clk;

  dslot_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .ins_done(ins_done),
    .is_branch(is_branch), .br_taken(br_taken), .br_slot(br_slot),
    .br_target(br_target), .is_prefix(is_prefix), .is_brk(is_brk),
    .is_halt(is_halt), .is_unknown(is_unknown), .wb_we(wb_we), .wb_idx(wb_idx),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .pc(pc),
    .prefix_valid(prefix_valid), .rf_we(rf_we), .exc_valid(exc_valid),
    .exc_code(exc_code)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("pc", pc, m_pc);
    chk("fetch_addr", fetch_addr, m_pc & 32'hFFFF_FFFC);
    chk("fetch_req", {31'd0, fetch_req}, {31'd0, m_st != 2});
    chk("prefix", {31'd0, prefix_valid}, {31'd0, m_pre});
    chk("exc_valid", {31'd0, exc_valid}, {31'd0, m_ev});
    chk("exc_code", {30'd0, exc_code}, m_ev ? m_ec : 0);
  endtask

  task automatic model_step();
    bit slot, fault;
    m_ev = 0; m_ec = 0;
    if (!ins_done || m_st == 2) return;
    slot = (m_st == 1);
    fault = is_unknown || is_halt || (slot ? is_branch : is_brk);
    if (fault) begin
      m_st = 2; m_pre = 0; m_ev = 1;
      if (is_unknown || (slot && is_branch)) m_ec = 2;
      else if (is_halt) m_ec = 3;
      else m_ec = 1;
      return;
    end
    m_pre = is_prefix && !(slot && is_brk);
    if (slot) begin m_pc = m_tgt; m_st = 0; end
    else if (is_branch && br_taken && br_slot) begin m_tgt = br_target; m_pc = m_pc + 4; m_st = 1; end
    else if (is_branch && br_taken) m_pc = br_target;
    else m_pc = m_pc + 4;
    if (step_en) begin m_ev = 1; m_ec = 1; end
  endtask

  // One cycle: inputs set at negedge, model advanced, compared at next negedge.
  task automatic op(string r, bit v, bit br = 0, bit tk = 0, bit sl = 0,
                    logic [31:0] tg = 0, bit pre = 0, bit brk = 0,
                    bit hlt = 0, bit unk = 0);
    req = r;
    ins_done = v; is_branch = br; br_taken = tk; br_slot = sl; br_target = tg;
    is_prefix = pre; is_brk = brk; is_halt = hlt; is_unknown = unk;
    model_step();
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 0; ins_done = 0; step_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_st = 0; m_pc = 0; m_tgt = 0; m_pre = 0; m_ev = 0; m_ec = 0;
    req = "R1";
    @(negedge clk);
    compare();
  endtask

  task automatic wb(int idx, bit we, bit exp);
    req = "R13";
    wb_we = we; wb_idx = idx[4:0];
    #1;
    chk("rf_we", {31'd0, rf_we}, {31'd0, exp});
    wb_we = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    op("R3", 1); op("R3", 1); op("R9", 1, .pre(1)); op("R9", 1);
    op("R14", 0); op("R14", 0, .pre(1), .br(1), .tk(1), .tg(32'h40));
    op("R4", 1, .br(1), .tk(1), .tg(32'h100));
    op("R4", 1, .br(1), .tk(0), .tg(32'h800));
    op("R5", 1, .br(1), .tk(1), .sl(1), .tg(32'h203));
    op("R14", 0);
    op("R9", 1, .pre(1));                       // slot instr is prefix
    op("R2", 1);                                // at unaligned target
    op("R5", 1, .br(1), .tk(1), .sl(1), .tg(32'h300));
    op("R7", 1, .brk(1));                       // breakpoint in slot dropped
    op("R3", 1);
    wb(0, 1, 0); wb(7, 1, 1); wb(31, 1, 1); wb(0, 0, 0);
    step_en = 1;
    op("R12", 1); op("R12", 1, .br(1), .tk(1), .sl(1), .tg(32'h500));
    op("R12", 1); op("R12", 0); op("R12", 1, .br(1), .tk(1), .tg(32'h40));
    step_en = 0;
    op("R8", 1, .brk(1)); op("R11", 1); op("R11", 1, .br(1), .tk(1), .tg(32'h9));
    do_reset();
    op("R5", 1, .br(1), .tk(1), .sl(1), .tg(32'h60));
    op("R6", 1, .br(1), .tk(1), .tg(32'h70)); op("R6", 1);
    do_reset();
    op("R3", 1); op("R10", 1, .hlt(1)); op("R10", 1);
    do_reset();
    op("R5", 1, .br(1), .tk(1), .sl(1), .tg(32'h80));
    op("R10", 1, .hlt(1));
    do_reset();
    op("R9", 1, .pre(1)); op("R11", 1, .unk(1)); op("R11", 1); op("R11", 1, .pre(1));
    step_en = 1; op("R11", 1); step_en = 0;
    do_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule